// File: doc/BRIEF.md
# Address-Space-Tagged Translation Lookaside Buffer

This block is a small, fully associative translation cache for a 32-bit virtual address space. Each lookup presents a virtual address, an address-space identifier and a write flag. The upper three address bits first choose a region. Two of the four region codes are unmapped kernel windows: for these the block skips the search and forms the physical address directly. The other codes are mapped. In a mapped region the 20-bit virtual page number and the 6-bit identifier are compared against every stored entry in the same cycle. A hit returns the physical page joined to the unchanged 12-bit offset, together with the entry's dirty and rights bits.

The block does not walk page tables. A miss in a mapped region raises a refill fault, and software then installs the missing mapping through the write port. A refill goes to the slot named by a round-robin pointer. The same port can invalidate the entries that match one page and identifier pair, or invalidate all entries. Because every entry carries the identifier, mappings from different address spaces can stay resident together, and a context switch needs no flush.

A store to a page that is not writable, or whose dirty bit is clear, raises a modification fault. This lets software track the first write to each page. If more than one valid entry matches a lookup, an error flag is raised.

Top module: `asid_tlb`

## Requirements
- R1: After a synchronous active-low reset, every entry is invalid and `refill_slot` is 0, so any valid lookup in a mapped region misses.
- R2: A lookup hits only when a stored entry is valid and both its page number and its identifier equal the lookup's. On a hit, `lk_paddr` is the entry's physical page followed by `lk_vaddr[11:0]`.
- R3: Two entries with the same page number but different identifiers coexist, and each translates only for its own identifier. A third identifier misses.
- R4: `miss_fault` is 1 exactly when `lk_valid` is 1, the region is mapped (top bits `0xx` or `11x`) and no entry matches. It is 0 whenever `lk_valid` is 0.
- R5: Top bits `100` and `101` bypass the search. `lk_paddr` equals `lk_vaddr` with bits 31:29 cleared, `lk_hit` and both faults are 0, and `lk_cacheable` is 1 for `100` and 0 for `101`.
- R6: `mod_fault` is 1 when a lookup with `lk_write` = 1 hits an entry whose rights bit 1 (write allowed) is 0 or whose dirty bit is 0. Reads and writable dirty pages give no such fault. Rights bit 0 means read allowed.
- R7: `wr_cmd` = 2'b00 (refill) writes the supplied entry into slot `refill_slot`. The pointer then steps by one and wraps from 63 to 0.
- R8: `wr_cmd` = 2'b01 clears Valid on every entry whose page number and identifier equal `wr_vpn`/`wr_asid`. All other entries are left unchanged.
- R9: `wr_cmd` = 2'b10 clears Valid on all entries and leaves `refill_slot` unchanged. `wr_cmd` = 2'b11 does nothing.
- R10: `multi_hit` is 1 when a valid mapped lookup matches two or more valid entries.
- R11: A lookup in the same cycle as a write sees the contents from before that write. The write's effect is visible from the cycle after the clock edge.
- R12: A mapped hit drives `lk_cacheable` = 1 and reports the entry's dirty bit on `lk_dirty` and its rights on `lk_rights`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lk_valid | input | 1 | Lookup request present |
| lk_vaddr | input | 32 | Virtual address to translate |
| lk_asid | input | 6 | Address-space identifier of the lookup |
| lk_write | input | 1 | Lookup is a store |
| lk_paddr | output | 32 | Translated physical address |
| lk_hit | output | 1 | Mapped lookup found a valid entry |
| lk_cacheable | output | 1 | Access may be cached |
| lk_dirty | output | 1 | Dirty bit of the hitting entry |
| lk_rights | output | 2 | Rights of the hitting entry (bit1 write, bit0 read) |
| miss_fault | output | 1 | Refill fault for software |
| mod_fault | output | 1 | Store to non-writable or clean page |
| multi_hit | output | 1 | More than one entry matched |
| wr_en | input | 1 | Write-port command strobe |
| wr_cmd | input | 2 | 00 refill, 01 invalidate match, 10 invalidate all, 11 none |
| wr_vpn | input | 20 | Virtual page for refill or invalidate match |
| wr_asid | input | 6 | Identifier for refill or invalidate match |
| wr_ppn | input | 20 | Physical page for refill |
| wr_dirty | input | 1 | Dirty bit for refill |
| wr_ref | input | 1 | Referenced bit for refill |
| wr_valid | input | 1 | Valid bit for refill |
| wr_rights | input | 2 | Rights for refill |
| refill_slot | output | 6 | Slot the next refill will write |

## Verification
A lookup and a write-port command can fall in the same cycle. The case that matters most is an invalidate of the very page that is being translated. The bench drives both in one cycle and samples before the clock edge, where the lookup must still hit with the old physical page. It samples again just after the edge, where the same lookup must now miss and raise the refill fault, while an entry with another identifier must still translate. A duplicate refill first makes the multiple-hit flag rise, and the same invalidate is then judged to clear both copies at once.

// File: rtl/tlb_pkg.sv
// Shared widths, command codes and entry layout for the translation buffer.
// Assumes a 32-bit virtual and a 32-bit physical address with 4 KiB pages.
package tlb_pkg;
    localparam int VPN_W  = 20;
    localparam int OFF_W  = 12;
    localparam int ASID_W = 6;
    localparam int PPN_W  = 20;
    localparam int RGT_W  = 2;
    localparam int SEG_W  = 3;
    localparam int VA_W   = VPN_W + OFF_W;
    localparam int PA_W   = PPN_W + OFF_W;

    typedef enum logic [1:0] {
        CMD_REFILL  = 2'b00,
        CMD_INV_ONE = 2'b01,
        CMD_INV_ALL = 2'b10,
        CMD_NOP     = 2'b11
    } tlb_cmd_e;

    typedef enum logic [1:0] {
        SEG_USER,
        SEG_KPHYS_C,
        SEG_KPHYS_U,
        SEG_KMAP
    } seg_e;

    typedef struct packed {
        logic [VPN_W-1:0]  vpn;
        logic [ASID_W-1:0] asid;
        logic [PPN_W-1:0]  ppn;
        logic              dirty;
        logic              refd;
        logic              valid;
        logic [RGT_W-1:0]  rights;
    } tlb_entry_t;
endpackage

// File: rtl/tlb_seg_decode.sv
// Region decoder: classifies a virtual address by its top three bits and
// forms the direct physical address for the unmapped kernel windows.
// Assumes PA_W equals VA_W so that clearing the top bits is a plain copy.
module tlb_seg_decode
    import tlb_pkg::*;
(
    input  logic [VA_W-1:0] vaddr,
    output seg_e            seg,
    output logic            bypass,
    output logic            phys_cache,
    output logic [PA_W-1:0] phys_addr
);
    localparam int LOW_W = VA_W - SEG_W;

    // Decode the region code and derive bypass and cacheability.
    always_comb begin
        unique casez (vaddr[VA_W-1 -: SEG_W])
            3'b0??:  seg = SEG_USER;
            3'b100:  seg = SEG_KPHYS_C;
            3'b101:  seg = SEG_KPHYS_U;
            default: seg = SEG_KMAP;
        endcase
        bypass     = (seg == SEG_KPHYS_C) || (seg == SEG_KPHYS_U);
        phys_cache = (seg == SEG_KPHYS_C);
        phys_addr  = {{SEG_W{1'b0}}, vaddr[LOW_W-1:0]};
    end
endmodule

// File: rtl/tlb_store.sv
// Entry storage with the software write port and the parallel tag compare.
// Refills go to a round-robin slot; invalidates clear Valid only.
// Assumes ENTRIES is a power of two no smaller than 2.
module tlb_store
    import tlb_pkg::*;
#(
    parameter int ENTRIES = 64,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  tlb_cmd_e                  wr_cmd,
    input  tlb_entry_t                wr_entry,
    input  logic [VPN_W-1:0]          lk_vpn,
    input  logic [ASID_W-1:0]         lk_asid,
    output tlb_entry_t [ENTRIES-1:0]  ent,
    output logic [ENTRIES-1:0]        match,
    output logic [IDX_W-1:0]          slot
);
    logic [ENTRIES-1:0] inv_match;
    logic [ENTRIES-1:0] valid_vec;

    // Per-entry compare against the lookup tag and the invalidate tag.
    for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
        assign valid_vec[i] = ent[i].valid;
        assign match[i]     = ent[i].valid && (ent[i].vpn == lk_vpn)
                              && (ent[i].asid == lk_asid);
        assign inv_match[i] = ent[i].valid && (ent[i].vpn == wr_entry.vpn)
                              && (ent[i].asid == wr_entry.asid);
    end

    // Apply write-port commands and step the refill pointer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ent  <= '0;
            slot <= '0;
        end else if (wr_en) begin
            unique case (wr_cmd)
                CMD_REFILL: begin
                    ent[slot] <= wr_entry;
                    slot      <= (slot == IDX_W'(ENTRIES - 1)) ? '0 : slot + 1'b1;
                end
                CMD_INV_ONE: begin
                    for (int i = 0; i < ENTRIES; i++)
                        if (inv_match[i]) ent[i].valid <= 1'b0;
                end
                CMD_INV_ALL: begin
                    for (int i = 0; i < ENTRIES; i++)
                        ent[i].valid <= 1'b0;
                end
                default: ;
            endcase
        end
    end

    assert_refill_lands_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_cmd == CMD_REFILL) |=> (ent[$past(slot)] == $past(wr_entry)));

    assert_slot_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && wr_cmd == CMD_REFILL) |=> $stable(slot));

    assert_flush_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_cmd == CMD_INV_ALL) |=> (valid_vec == '0));

    assert_inv_spares_others_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_cmd == CMD_INV_ONE) |=>
        ((valid_vec & ~$past(inv_match)) == ($past(valid_vec) & ~$past(inv_match))));
endmodule

// File: rtl/tlb_select.sv
// Result selection: merges the matching entries with an AND-OR tree and
// flags a multiple match. Assumes at most one match in normal operation;
// on a multiple match the merged entry is meaningless and only flagged.
module tlb_select
    import tlb_pkg::*;
#(
    parameter int ENTRIES = 64
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  tlb_entry_t [ENTRIES-1:0] ent,
    input  logic [ENTRIES-1:0]       match,
    output logic                     any_hit,
    output logic                     multi,
    output tlb_entry_t               sel
);
    // OR together every matching entry; a single match passes unchanged.
    always_comb begin
        sel = '0;
        for (int i = 0; i < ENTRIES; i++)
            if (match[i]) sel = sel | ent[i];
        any_hit = |match;
        multi   = |(match & (match - 1'b1));
    end

    assert_multi_count_R10: assert property (@(posedge clk) disable iff (!rst_n)
        multi == ($countones(match) > 1));
endmodule

// File: rtl/asid_tlb.sv
// Top level of the identifier-tagged translation buffer. The lookup is
// combinational from the lookup inputs and the stored entries; the write
// port updates storage at the clock edge. Assumes 4 KiB pages, 32-bit
// addresses and a software refill handler driven by miss_fault.
module asid_tlb
    import tlb_pkg::*;
#(
    parameter int ENTRIES = 64,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lk_valid,
    input  logic [VA_W-1:0]   lk_vaddr,
    input  logic [ASID_W-1:0] lk_asid,
    input  logic              lk_write,
    output logic [PA_W-1:0]   lk_paddr,
    output logic              lk_hit,
    output logic              lk_cacheable,
    output logic              lk_dirty,
    output logic [RGT_W-1:0]  lk_rights,
    output logic              miss_fault,
    output logic              mod_fault,
    output logic              multi_hit,
    input  logic              wr_en,
    input  logic [1:0]        wr_cmd,
    input  logic [VPN_W-1:0]  wr_vpn,
    input  logic [ASID_W-1:0] wr_asid,
    input  logic [PPN_W-1:0]  wr_ppn,
    input  logic              wr_dirty,
    input  logic              wr_ref,
    input  logic              wr_valid,
    input  logic [RGT_W-1:0]  wr_rights,
    output logic [IDX_W-1:0]  refill_slot
);
    seg_e                     seg;
    logic                     bypass;
    logic                     phys_cache;
    logic [PA_W-1:0]          phys_addr;
    tlb_entry_t               wr_entry;
    tlb_entry_t [ENTRIES-1:0] ent;
    logic [ENTRIES-1:0]       match;
    logic                     any_hit;
    logic                     multi;
    tlb_entry_t               sel;
    logic                     mapped_req;

    // Assemble the entry presented on the write port.
    always_comb begin
        wr_entry.vpn    = wr_vpn;
        wr_entry.asid   = wr_asid;
        wr_entry.ppn    = wr_ppn;
        wr_entry.dirty  = wr_dirty;
        wr_entry.refd   = wr_ref;
        wr_entry.valid  = wr_valid;
        wr_entry.rights = wr_rights;
    end

    tlb_seg_decode u_seg (
        .vaddr      (lk_vaddr),
        .seg        (seg),
        .bypass     (bypass),
        .phys_cache (phys_cache),
        .phys_addr  (phys_addr)
    );

    tlb_store #(.ENTRIES(ENTRIES)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_cmd   (tlb_cmd_e'(wr_cmd)),
        .wr_entry (wr_entry),
        .lk_vpn   (lk_vaddr[VA_W-1 -: VPN_W]),
        .lk_asid  (lk_asid),
        .ent      (ent),
        .match    (match),
        .slot     (refill_slot)
    );

    tlb_select #(.ENTRIES(ENTRIES)) u_sel (
        .clk     (clk),
        .rst_n   (rst_n),
        .ent     (ent),
        .match   (match),
        .any_hit (any_hit),
        .multi   (multi),
        .sel     (sel)
    );

    // Combine region decode and match result into the lookup outputs.
    always_comb begin
        mapped_req   = lk_valid && !bypass;
        lk_hit       = mapped_req && any_hit;
        miss_fault   = mapped_req && !any_hit;
        multi_hit    = mapped_req && multi;
        mod_fault    = lk_hit && lk_write && !(sel.rights[1] && sel.dirty);
        lk_dirty     = lk_hit && sel.dirty;
        lk_rights    = lk_hit ? sel.rights : '0;
        lk_cacheable = bypass ? phys_cache : lk_hit;
        if (bypass)       lk_paddr = phys_addr;
        else if (any_hit) lk_paddr = {sel.ppn, lk_vaddr[OFF_W-1:0]};
        else              lk_paddr = '0;
    end

    assert_hit_miss_exclusive_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(lk_hit && miss_fault));

    assert_bypass_no_fault_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && seg inside {SEG_KPHYS_C, SEG_KPHYS_U}) |-> (!miss_fault && !mod_fault && !lk_hit));

    assert_mod_needs_store_hit_R6: assert property (@(posedge clk) disable iff (!rst_n)
        mod_fault |-> (lk_hit && lk_write));

    assert_multi_implies_hit_R10: assert property (@(posedge clk) disable iff (!rst_n)
        multi_hit |-> lk_hit);
endmodule

// File: tb/asid_tlb_tb.sv
module asid_tlb_tb;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        lk_valid;
    logic [31:0] lk_vaddr;
    logic [5:0]  lk_asid;
    logic        lk_write;
    logic [31:0] lk_paddr;
    logic        lk_hit, lk_cacheable, lk_dirty;
    logic [1:0]  lk_rights;
    logic        miss_fault, mod_fault, multi_hit;
    logic        wr_en;
    logic [1:0]  wr_cmd;
    logic [19:0] wr_vpn;
    logic [5:0]  wr_asid;
    logic [19:0] wr_ppn;
    logic        wr_dirty, wr_ref, wr_valid;
    logic [1:0]  wr_rights;
    logic [5:0]  refill_slot;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;   // 250 MHz

    asid_tlb u_dut (
        .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_vaddr(lk_vaddr),
        .lk_asid(lk_asid), .lk_write(lk_write), .lk_paddr(lk_paddr),
        .lk_hit(lk_hit), .lk_cacheable(lk_cacheable), .lk_dirty(lk_dirty),
        .lk_rights(lk_rights), .miss_fault(miss_fault), .mod_fault(mod_fault),
        .multi_hit(multi_hit), .wr_en(wr_en), .wr_cmd(wr_cmd), .wr_vpn(wr_vpn),
        .wr_asid(wr_asid), .wr_ppn(wr_ppn), .wr_dirty(wr_dirty), .wr_ref(wr_ref),
        .wr_valid(wr_valid), .wr_rights(wr_rights), .refill_slot(refill_slot)
    );

    // Vector: vaddr[74:43] asid[42:37] write[36] hit[35] miss[34] mod[33] cache[32] paddr[31:0]
    localparam int NVEC = 12;
    localparam logic [74:0] VEC [NVEC] = '{
        {32'h00010ABC, 6'd1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 32'h0ABCDABC}, // R2 R12
        {32'h00010123, 6'd2, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 32'h01234123}, // R3
        {32'h00010123, 6'd3, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 32'h00000000}, // R3 R4
        {32'h00010FFF, 6'd1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 32'h0ABCDFFF}, // R6 writable dirty
        {32'h00010004, 6'd2, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 32'h01234004}, // R6 read-only
        {32'hC0005010, 6'd1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 32'h00777010}, // R6 clean page
        {32'hC0005010, 6'd1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 32'h00777010}, // R6 read no fault
        {32'h80001234, 6'd5, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 32'h00001234}, // R5 cached window
        {32'hA0001234, 6'd5, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 32'h00001234}, // R5 uncached window
        {32'h9FFFFFFF, 6'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 32'h1FFFFFFF}, // R5 window top
        {32'h00020000, 6'd1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 32'h00000000}, // R4 user miss
        {32'hC0005010, 6'd2, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 32'h00000000}  // R3 kernel-mapped other id
    };

    // Compare one value and report a mismatch.
    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Present a lookup and let the combinational result settle.
    task automatic look(input logic [31:0] va, input logic [5:0] id, input logic wr);
        @(negedge clk);
        lk_valid = 1'b1; lk_vaddr = va; lk_asid = id; lk_write = wr;
        #1;
    endtask

    // Issue one write-port command for one clock edge.
    task automatic wcmd(input logic [1:0] cmd, input logic [19:0] vpn, input logic [5:0] id,
                        input logic [19:0] ppn, input logic d, input logic [1:0] rg);
        @(negedge clk);
        wr_en = 1'b1; wr_cmd = cmd; wr_vpn = vpn; wr_asid = id; wr_ppn = ppn;
        wr_dirty = d; wr_ref = 1'b1; wr_valid = 1'b1; wr_rights = rg;
        @(negedge clk);
        wr_en = 1'b0; wr_cmd = 2'b11;
    endtask

    initial begin
        #(4 * 100000);
        checks++; errors++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        rst_n = 1'b0; lk_valid = 1'b0; lk_vaddr = '0; lk_asid = '0; lk_write = 1'b0;
        wr_en = 1'b0; wr_cmd = 2'b11; wr_vpn = '0; wr_asid = '0; wr_ppn = '0;
        wr_dirty = 1'b0; wr_ref = 1'b0; wr_valid = 1'b0; wr_rights = '0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;

        // R1: empty after reset
        look(32'h00001000, 6'd1, 1'b0);
        check("R1 slot", 32'(refill_slot), 32'd0);
        check("R1 miss", 32'(miss_fault), 32'd1);
        check("R1 hit", 32'(lk_hit), 32'd0);

        // R4: no fault without a request
        @(negedge clk); lk_valid = 1'b0; #1;
        check("R4 idle miss", 32'(miss_fault), 32'd0);

        wcmd(2'b00, 20'h00010, 6'd1, 20'h0ABCD, 1'b1, 2'b11);
        wcmd(2'b00, 20'h00010, 6'd2, 20'h01234, 1'b1, 2'b01);
        wcmd(2'b00, 20'hC0005, 6'd1, 20'h00777, 1'b0, 2'b11);
        check("R7 slot after 3", 32'(refill_slot), 32'd3);
        wcmd(2'b11, 20'h00010, 6'd1, 20'h0FFFF, 1'b1, 2'b11);
        check("R9 nop slot", 32'(refill_slot), 32'd3);

        for (int v = 0; v < NVEC; v++) begin
            look(VEC[v][74:43], VEC[v][42:37], VEC[v][36]);
            check($sformatf("table %0d hit", v), 32'(lk_hit), 32'(VEC[v][35]));
            check($sformatf("table %0d miss", v), 32'(miss_fault), 32'(VEC[v][34]));
            check($sformatf("table %0d mod", v), 32'(mod_fault), 32'(VEC[v][33]));
            check($sformatf("table %0d cache", v), 32'(lk_cacheable), 32'(VEC[v][32]));
            if (!VEC[v][34])
                check($sformatf("table %0d paddr", v), lk_paddr, VEC[v][31:0]);
        end

        // R12: reported attributes
        look(32'hC0005010, 6'd1, 1'b0);
        check("R12 dirty clean", 32'(lk_dirty), 32'd0);
        look(32'h00010004, 6'd2, 1'b0);
        check("R12 rights", 32'(lk_rights), 32'd1);
        check("R12 dirty", 32'(lk_dirty), 32'd1);

        // R10: duplicate mapping
        wcmd(2'b00, 20'h00010, 6'd1, 20'h0DEAD, 1'b1, 2'b11);
        look(32'h00010000, 6'd1, 1'b0);
        check("R10 multi", 32'(multi_hit), 32'd1);
        look(32'h00010000, 6'd2, 1'b0);
        check("R10 single", 32'(multi_hit), 32'd0);

        // R11 / R8: invalidate in the same cycle as a lookup of that page
        @(negedge clk);
        lk_vaddr = 32'h00010000; lk_asid = 6'd1; lk_write = 1'b0;
        wr_en = 1'b1; wr_cmd = 2'b01; wr_vpn = 20'h00010; wr_asid = 6'd1;
        #1;
        check("R11 old hit", 32'(lk_hit), 32'd1);
        @(posedge clk); #1;
        check("R8 now miss", 32'(miss_fault), 32'd1);
        check("R8 no multi", 32'(multi_hit), 32'd0);
        @(negedge clk); wr_en = 1'b0; wr_cmd = 2'b11;
        look(32'h00010ABC, 6'd2, 1'b0);
        check("R8 other id kept", lk_paddr, 32'h01234ABC);
        look(32'hC0005000, 6'd1, 1'b0);
        check("R8 other page kept", 32'(lk_hit), 32'd1);

        // R7: fill to wrap
        check("R7 slot 4", 32'(refill_slot), 32'd4);
        for (int i = 0; i < 60; i++)
            wcmd(2'b00, 20'h00100 + 20'(i), 6'd7, 20'(i + 1), 1'b1, 2'b11);
        check("R7 wrap", 32'(refill_slot), 32'd0);
        wcmd(2'b00, 20'h00500, 6'd7, 20'h00055, 1'b1, 2'b11);
        check("R7 after wrap", 32'(refill_slot), 32'd1);
        look(32'h00500123, 6'd7, 1'b0);
        check("R7 slot0 new", lk_paddr, 32'h00055123);
        look(32'h00010ABC, 6'd1, 1'b0);
        check("R7 slot0 replaced", 32'(lk_hit), 32'd0);
        look(32'h00100008, 6'd7, 1'b0);
        check("R7 slot4 entry", lk_paddr, 32'h00001008);

        // R9: invalidate all
        wcmd(2'b10, 20'h0, 6'd0, 20'h0, 1'b0, 2'b00);
        check("R9 slot kept", 32'(refill_slot), 32'd1);
        look(32'h00100008, 6'd7, 1'b0);
        check("R9 flushed", 32'(miss_fault), 32'd1);
        look(32'h00010123, 6'd2, 1'b0);
        check("R9 flushed id2", 32'(lk_hit), 32'd0);
        look(32'hA0000040, 6'd2, 1'b0);
        check("R5 after flush", lk_paddr, 32'h00000040);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule